// File: doc/BRIEF.md
# Power Event Status and Enable Registers with Level Interrupt

This block holds two 16-bit power-management event registers and forms a level-sensitive system control interrupt from them. Hardware event strobes set latched flags in the status register. Software clears only a chosen subset of those flags by writing ones to them. The enable register selects which flags may raise the interrupt. Software can set only two of its bits.

Software reaches both registers through a simple single-cycle access port. Each access carries an offset and a size code. Only halfword accesses at the two defined offsets are accepted. Any other access is refused with an error flag, and it leaves all state unchanged.

The interrupt line is registered, and it is computed from the next-state values of both registers. It therefore changes on the same clock edge as the register change that causes it. It stays high for as long as any enabled source flag is set.

Top module: `pm_evt_regs`

## Requirements
- R1: After an asynchronous reset, the status register and the enable register both read 0x0000, and `sci_o` and `err_o` are low.
- R2: A high on `evt_i[n]` at a clock edge sets status bit n at that edge. This holds for the implemented positions: 0 timer, 4 bus master, 5 global, 8 power button, 9 sleep button, 10 RTC, 15 wake. All other positions stay 0, so an all-ones event pulse reads back as 0x8731.
- R3: The power-button event (bit 8) sets its status bit only while `acpi_en_i` is high. With `acpi_en_i` low, the pulse has no effect.
- R4: A status write clears each bit that has a one in the write data and belongs to the clearable set {15, 10, 9, 8, 4}. Bits 0 and 5 are not changed by writes, and zeros in the write data clear nothing.
- R5: An enable write stores only bits 8 and 5 of the write data. Every other enable bit stays 0, so writing 0xFFFF reads back as 0x0120.
- R6: `sci_o` is high exactly when the status register ANDed with the enable register has a one at position 0, 5, 8, 9 or 10. Bits 4 and 15 never drive it. It reflects a register change on the same edge that makes the change.
- R7: An access is accepted only when `size_i` is 2'd1 (16-bit). Any other size sets `err_o` in the following cycle, returns `rdata_o` = 0 and leaves both registers unchanged.
- R8: Offset 0 selects the status register and offset 2 selects the enable register. Offsets 1 and 3 are refused as in R7.
- R9: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: An accepted read returns the register value on `rdata_o` in the cycle after the request, with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset: 0 status, 2 enable |
| size_i | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the request |
| err_o | output | 1 | Refused access, the cycle after the request |
| evt_i | input | 16 | Hardware event strobes, one per status position |
| acpi_en_i | input | 1 | Gates acceptance of power-button events |
| sci_o | output | 1 | Level interrupt |

## Verification
The status path is driven with an all-ones event pulse and then with single-bit pulses. The all-ones pulse exposes the implemented-bit mask. The single-bit pulses show that each flag is latched on its own. All-ones and all-zeros clearing writes separate the clearable flags from the sticky timer and global flags. An all-ones enable write exposes the narrow writable mask. The interrupt is then exercised with a power-button source and with bus-master and wake flags. These cases tell a source that is enabled and pending apart from flags that must never drive the line. Refused sizes and odd offsets, a gated power-button pulse, and a same-cycle event and clear confirm that those inputs leave the registers unchanged or resolve toward set.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  parameter int unsigned REG_W = 16;

  // status positions that exist in hardware
  parameter logic [REG_W-1:0] STS_IMPL_MASK = 16'h8731;
  // status positions software may clear
  parameter logic [REG_W-1:0] STS_W1C_MASK  = 16'h8710;
  // enable positions software may set
  parameter logic [REG_W-1:0] EN_WR_MASK    = 16'h0120;
  // positions that may drive the interrupt
  parameter logic [REG_W-1:0] SCI_SRC_MASK  = 16'h0721;

  parameter int unsigned PWRBTN_BIT = 8;

  parameter logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode #(
  parameter int unsigned ADDR_W  = 2,
  parameter logic [ADDR_W-1:0] STS_OFS = 'd0,
  parameter logic [ADDR_W-1:0] EN_OFS  = 'd2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output pm_evt_pkg::reg_sel_e sel_o,
  output logic              sts_wr_o,
  output logic              en_wr_o,
  output logic              rd_o,
  output logic              bad_o
);
  import pm_evt_pkg::*;

  logic size_ok;

  assign size_ok = (size_i == SIZE_HALF);

  always_comb begin
    sel_o = SEL_NONE;
    if (size_ok) begin
      if (addr_i == STS_OFS)     sel_o = SEL_STS;
      else if (addr_i == EN_OFS) sel_o = SEL_EN;
    end
  end

  assign bad_o    = req_i && (sel_o == SEL_NONE);
  assign sts_wr_o = req_i && we_i && (sel_o == SEL_STS);
  assign en_wr_o  = req_i && we_i && (sel_o == SEL_EN);
  assign rd_o     = req_i && !we_i && (sel_o != SEL_NONE);
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status #(
  parameter int unsigned REG_W = pm_evt_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt_i,
  input  logic             acpi_en_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_d_o,
  output logic [REG_W-1:0] sts_q_o
);
  import pm_evt_pkg::*;

  logic [REG_W-1:0] gate;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    gate = STS_IMPL_MASK;
    gate[PWRBTN_BIT] = STS_IMPL_MASK[PWRBTN_BIT] & acpi_en_i;
  end

  assign set_vec = evt_i & gate;
  assign clr_vec = wr_i ? (wdata_i & STS_W1C_MASK) : '0;
  // set dominates a simultaneous clear
  assign sts_d_o = (set_vec | (sts_q_o & ~clr_vec)) & STS_IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q_o <= '0;
    else         sts_q_o <= sts_d_o;
  end
endmodule

// File: rtl/pm_evt_enable.sv
module pm_evt_enable #(
  parameter int unsigned REG_W = pm_evt_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_d_o,
  output logic [REG_W-1:0] en_q_o
);
  import pm_evt_pkg::*;

  assign en_d_o = wr_i ? (wdata_i & EN_WR_MASK) : en_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= '0;
    else         en_q_o <= en_d_o;
  end
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci #(
  parameter int unsigned REG_W = pm_evt_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] sts_d_i,
  input  logic [REG_W-1:0] en_d_i,
  output logic             sci_o
);
  import pm_evt_pkg::*;

  logic [REG_W-1:0] hit;

  for (genvar i = 0; i < REG_W; i++) begin : g_hit
    if (SCI_SRC_MASK[i]) begin : g_src
      assign hit[i] = sts_d_i[i] & en_d_i[i];
    end else begin : g_nosrc
      assign hit[i] = 1'b0;
    end
  end

  // registered from next state so it moves with the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_o <= 1'b0;
    else         sci_o <= |hit;
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
  parameter int unsigned REG_W  = pm_evt_pkg::REG_W,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              err_o,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              acpi_en_i,
  output logic              sci_o
);
  import pm_evt_pkg::*;

  reg_sel_e         sel;
  logic             sts_wr;
  logic             en_wr;
  logic             rd;
  logic             bad;
  logic [REG_W-1:0] sts_d;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] en_q;

  pm_evt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .sel_o   (sel),
    .sts_wr_o(sts_wr),
    .en_wr_o (en_wr),
    .rd_o    (rd),
    .bad_o   (bad)
  );

  pm_evt_status #(.REG_W(REG_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .acpi_en_i(acpi_en_i),
    .wr_i     (sts_wr),
    .wdata_i  (wdata_i),
    .sts_d_o  (sts_d),
    .sts_q_o  (sts_q)
  );

  pm_evt_enable #(.REG_W(REG_W)) u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (en_wr),
    .wdata_i(wdata_i),
    .en_d_o (en_d),
    .en_q_o (en_q)
  );

  pm_evt_sci #(.REG_W(REG_W)) u_sci (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_d_i(sts_d),
    .en_d_i (en_d),
    .sci_o  (sci_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= bad;
      if (rd) rdata_o <= (sel == SEL_STS) ? sts_q : en_q;
      else    rdata_o <= '0;
    end
  end
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
  parameter int unsigned REG_W = pm_evt_pkg::REG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [1:0]       size_i,
  input logic             err_o,
  input logic             acpi_en_i,
  input logic [REG_W-1:0] evt_i,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] en_q,
  input logic             sci_o
);
  import pm_evt_pkg::*;

  // R6
  sci_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o == (|(sts_q & en_q & SCI_SRC_MASK)));

  // R5
  en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~EN_WR_MASK) == '0);

  // R7
  bad_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != SIZE_HALF) |=> err_o);

  // R7
  bad_size_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != SIZE_HALF) |=> $stable(en_q));

  // R3
  pwrbtn_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[PWRBTN_BIT]) |-> $past(evt_i[PWRBTN_BIT] && acpi_en_i));

  // R4
  sticky_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sts_q[0]));

  // R4
  sticky_gbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sts_q[5]));
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.REG_W(REG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .size_i   (size_i),
  .err_o    (err_o),
  .acpi_en_i(acpi_en_i),
  .evt_i    (evt_i),
  .sts_q    (sts_q),
  .en_q     (en_q),
  .sci_o    (sci_o)
);

// File: tb/pm_evt_regs_bench.sv
`timescale 1ns/1ps
module pm_evt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [1:0]  size = 2'd1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err;
  logic [15:0] evt = '0;
  logic        acpi_en = 1'b0;
  logic        sci;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] rd_v;
  logic        er_v;

  always #2 clk = ~clk;

  pm_evt_regs u_pm_evt_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .evt_i(evt), .acpi_en_i(acpi_en), .sci_o(sci)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 0; evt = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input logic w, input logic [1:0] a, input logic [1:0] s,
                        input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd_v = rdata; er_v = err;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sci", {15'd0, sci}, 16'h0);
    chk("R1 err", {15'd0, err}, 16'h0);
    access(0, 2'd0, 2'd1, 0);
    chk("R1 status", rd_v, 16'h0000);
    chk("R10 err on good read", {15'd0, er_v}, 16'h0);
    access(0, 2'd2, 2'd1, 0);
    chk("R1 enable", rd_v, 16'h0000);
  endtask

  task automatic t_events();
    do_reset();
    acpi_en = 1'b1;
    pulse(16'hFFFF);
    access(0, 2'd0, 2'd1, 0);
    chk("R2 all ones", rd_v, 16'h8731);
    chk("R6 nothing enabled", {15'd0, sci}, 16'h0);
    do_reset();
    pulse(16'h0400);
    access(0, 2'd0, 2'd1, 0);
    chk("R2 rtc single", rd_v, 16'h0400);
  endtask

  task automatic t_w1c();
    do_reset();
    acpi_en = 1'b1;
    pulse(16'hFFFF);
    access(1, 2'd0, 2'd1, 16'h0000);
    access(0, 2'd0, 2'd1, 0);
    chk("R4 zeros clear nothing", rd_v, 16'h8731);
    access(1, 2'd0, 2'd1, 16'hFFFF);
    access(0, 2'd0, 2'd1, 0);
    chk("R4 only clearable bits", rd_v, 16'h0021);
  endtask

  task automatic t_enable_sci();
    do_reset();
    acpi_en = 1'b1;
    access(1, 2'd2, 2'd1, 16'hFFFF);
    access(0, 2'd2, 2'd1, 0);
    chk("R5 enable mask", rd_v, 16'h0120);
    pulse(16'h8010);
    chk("R6 bm/wake no sci", {15'd0, sci}, 16'h0);
    pulse(16'h0100);
    chk("R6 pwrbtn sci high", {15'd0, sci}, 16'h1);
    access(1, 2'd0, 2'd1, 16'h0100);
    chk("R6 cleared sci low", {15'd0, sci}, 16'h0);
    pulse(16'h0020);
    chk("R6 global sci high", {15'd0, sci}, 16'h1);
    access(1, 2'd2, 2'd1, 16'h0000);
    chk("R6 disabled sci low", {15'd0, sci}, 16'h0);
  endtask

  task automatic t_gate();
    do_reset();
    acpi_en = 1'b0;
    pulse(16'h0100);
    access(0, 2'd0, 2'd1, 0);
    chk("R3 gated pwrbtn", rd_v, 16'h0000);
    acpi_en = 1'b1;
    pulse(16'h0100);
    access(0, 2'd0, 2'd1, 0);
    chk("R3 ungated pwrbtn", rd_v, 16'h0100);
  endtask

  task automatic t_bad();
    do_reset();
    access(1, 2'd2, 2'd1, 16'h0100);
    access(1, 2'd2, 2'd0, 16'h0000);
    chk("R7 byte write err", {15'd0, er_v}, 16'h1);
    access(0, 2'd2, 2'd1, 0);
    chk("R7 enable unchanged", rd_v, 16'h0100);
    access(0, 2'd2, 2'd2, 0);
    chk("R7 word read err", {15'd0, er_v}, 16'h1);
    chk("R7 word read data", rd_v, 16'h0000);
    access(1, 2'd1, 2'd1, 16'h0000);
    chk("R8 odd offset err", {15'd0, er_v}, 16'h1);
    access(1, 2'd3, 2'd1, 16'h0000);
    chk("R8 offset 3 err", {15'd0, er_v}, 16'h1);
    access(0, 2'd2, 2'd1, 0);
    chk("R8 enable still set", rd_v, 16'h0100);
  endtask

  task automatic t_collide();
    do_reset();
    acpi_en = 1'b1;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 2'd0; size = 2'd1; wdata = 16'h0100;
    evt = 16'h0100;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    access(0, 2'd0, 2'd1, 0);
    chk("R9 set wins", rd_v, 16'h0100);
  endtask

  initial begin
    t_reset();
    t_events();
    t_w1c();
    t_enable_sci();
    t_gate();
    t_bad();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule